// File: doc/BRIEF.md
# Bank-Aware Slow Write Scheduler

This block sits in the write path of a memory controller for a resistive memory. Writebacks come from two queues. The main write queue holds ordinary evictions. The eager queue holds dirty lines that an outside predictor expects will not be written again. Every write the block issues is either a normal-speed write or a slow write. A slow write takes longer and costs more energy, but it wears the cells less. The block tracks how many writebacks are pending for each bank. A lightly loaded bank gets slow writes, and a heavily loaded bank gets normal writes.

Reads always win the cycle. The main queue is next in priority. The eager queue only uses cycles that neither of the others needs, and its writes are always slow. A wear budget limits how many normal-speed writes may be issued within one fixed-length period. Once that budget is spent, every write is slow until the period timer expires. If the main queue becomes full, the block switches to normal-speed writes so that the backlog drains. It returns to the load-based choice once the queue occupancy falls below a low-water mark.

Top module: `wear_write_sched`

## Requirements
- R1: A main-queue write whose bank has at most FREE_THRESH pending main-queue entries (the entry being issued included) is issued slow (wr_slow=1), unless fallback is active.
- R2: A main-queue write whose bank has more than FREE_THRESH pending entries is issued fast (wr_slow=0), unless the wear budget is spent.
- R3: A write issued to a bank in cycle t blocks that bank until cycle t+SLOW_CYCLES (slow write) or t+FAST_CYCLES (fast write). Writes to other banks are not blocked.
- R4: No write is issued in a cycle where rd_busy=1. Main-queue entries issue in arrival order, and a main-queue write takes the cycle ahead of any eager write.
- R5: An eager write issues only in a cycle where no main-queue write issues. It is always slow and is flagged with wr_eager=1.
- R6: Each queue drives its ready output low while full. A push offered while the queue is full is dropped and never issued.
- R7: After FAST_QUOTA fast writes within one period of PERIOD_CYCLES cycles, every write is slow. The budget refills when the period timer wraps.
- R8: A full main queue turns on fallback from the next cycle: main-queue writes are fast. Fallback turns off once the main-queue occupancy is below FALLBACK_LOW. R7 overrides fallback.
- R9: After reset both queues are empty, both ready outputs are high and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_busy | input | 1 | Read traffic owns this cycle; no write may issue |
| mq_push_valid | input | 1 | Offer a writeback to the main queue |
| mq_push_bank | input | log2(NUM_BANKS) | Bank of the offered main writeback |
| mq_push_ready | output | 1 | Main queue has room |
| eq_push_valid | input | 1 | Offer an eager writeback |
| eq_push_bank | input | log2(NUM_BANKS) | Bank of the offered eager writeback |
| eq_push_ready | output | 1 | Eager queue has room |
| wr_valid | output | 1 | A write command is issued this cycle |
| wr_bank | output | log2(NUM_BANKS) | Bank of the issued write |
| wr_slow | output | 1 | 1 = slow write, 0 = normal-speed write |
| wr_eager | output | 1 | Issued write comes from the eager queue |

## Verification
An accepted push becomes visible in the cycle after its clock edge. A write is issued in the same cycle that its entry reaches the queue head and its bank is idle, and wr_valid follows rd_busy without any register in between. The bench therefore records every issued command on the falling edge, together with a cycle stamp, and derives its checks from the recorded order, the speed flags and the cycle gaps (6 cycles after a slow write, 2 after a fast one). Fallback is checked as taking effect one cycle after the queue becomes full and clearing one cycle after occupancy drops below the mark. The wear budget is checked as taking effect on the write that follows the one that spends it.

// File: rtl/wws_pkg.sv
package wws_pkg;
  typedef enum logic {
    SPD_FAST = 1'b0,
    SPD_SLOW = 1'b1
  } speed_e;
endpackage

// File: rtl/wws_fifo.sv
module wws_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_v,
  input  logic [W-1:0]     push_d,
  output logic             push_rdy,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign push_rdy = !full;
  assign count    = cnt_q;
  assign head     = mem[rptr_q];
  assign do_push  = push_v && !full;
  assign do_pop   = pop && !empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= push_d;
  end
endmodule

// File: rtl/wws_bank_track.sv
module wws_bank_track #(
  parameter int NUM_BANKS   = 4,
  parameter int MQ_DEPTH    = 8,
  parameter int SLOW_CYCLES = 6,
  parameter int FAST_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic                         add_v,
  input  logic [$clog2(NUM_BANKS)-1:0] add_bank,
  input  logic                         sub_v,
  input  logic [$clog2(NUM_BANKS)-1:0] sub_bank,
  input  logic                         iss_v,
  input  logic [$clog2(NUM_BANKS)-1:0] iss_bank,
  input  logic                         iss_slow,
  output logic [NUM_BANKS-1:0][$clog2(MQ_DEPTH+1)-1:0] pend,
  output logic [NUM_BANKS-1:0]         busy
);
  localparam int BW = $clog2(NUM_BANKS);
  localparam int PW = $clog2(MQ_DEPTH + 1);
  localparam int LW = $clog2(SLOW_CYCLES + 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [PW-1:0] pend_q, pend_d;
    logic [LW-1:0] hold_q, hold_d;
    logic          inc, dec, hit;

    assign inc = add_v && (add_bank == BW'(b));
    assign dec = sub_v && (sub_bank == BW'(b));
    assign hit = iss_v && (iss_bank == BW'(b));

    always_comb begin
      pend_d = pend_q;
      if (inc && !dec)      pend_d = pend_q + 1'b1;
      else if (dec && !inc) pend_d = pend_q - 1'b1;
      hold_d = hold_q;
      if (hit)                hold_d = iss_slow ? LW'(SLOW_CYCLES - 1) : LW'(FAST_CYCLES - 1);
      else if (hold_q != '0)  hold_d = hold_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
        hold_q <= '0;
      end else begin
        pend_q <= pend_d;
        hold_q <= hold_d;
      end
    end

    assign pend[b] = pend_q;
    assign busy[b] = (hold_q != '0);
  end
endmodule

// File: rtl/wws_wear_quota.sv
module wws_wear_quota #(
  parameter int FAST_QUOTA    = 8,
  parameter int PERIOD_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_issue,
  output logic spent
);
  localparam int TW = $clog2(PERIOD_CYCLES);
  localparam int QW = $clog2(FAST_QUOTA + 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic [QW-1:0] used_q, used_d;
  logic          wrap;

  assign wrap  = (tmr_q == TW'(PERIOD_CYCLES - 1));
  assign spent = (used_q == QW'(FAST_QUOTA));

  always_comb begin
    tmr_d  = wrap ? '0 : tmr_q + 1'b1;
    used_d = used_q;
    if (wrap)                    used_d = fast_issue ? QW'(1) : '0;
    else if (fast_issue && !spent) used_d = used_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      used_q <= '0;
    end else begin
      tmr_q  <= tmr_d;
      used_q <= used_d;
    end
  end
endmodule

// File: rtl/wear_write_sched.sv
module wear_write_sched
  import wws_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int MQ_DEPTH      = 8,
  parameter int EQ_DEPTH      = 4,
  parameter int FREE_THRESH   = 2,
  parameter int FALLBACK_LOW  = 6,
  parameter int SLOW_CYCLES   = 6,
  parameter int FAST_CYCLES   = 2,
  parameter int FAST_QUOTA    = 8,
  parameter int PERIOD_CYCLES = 4096
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_busy,
  input  logic                         mq_push_valid,
  input  logic [$clog2(NUM_BANKS)-1:0] mq_push_bank,
  output logic                         mq_push_ready,
  input  logic                         eq_push_valid,
  input  logic [$clog2(NUM_BANKS)-1:0] eq_push_bank,
  output logic                         eq_push_ready,
  output logic                         wr_valid,
  output logic [$clog2(NUM_BANKS)-1:0] wr_bank,
  output logic                         wr_slow,
  output logic                         wr_eager
);
  localparam int BW     = $clog2(NUM_BANKS);
  localparam int PW     = $clog2(MQ_DEPTH + 1);
  localparam int MQ_CW  = $clog2(MQ_DEPTH + 1);
  localparam int EQ_CW  = $clog2(EQ_DEPTH + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_n_q    <= rst_meta_n;
    end
  end

  logic [BW-1:0]    mq_head, eq_head;
  logic             mq_empty, mq_full, eq_empty, eq_full;
  logic [MQ_CW-1:0] mq_count;
  logic [EQ_CW-1:0] eq_count;
  logic             main_go, eager_go;
  logic [NUM_BANKS-1:0][PW-1:0] pend;
  logic [NUM_BANKS-1:0] busy;
  logic             quota_hit;
  logic             fb_q, fb_d;
  speed_e           main_spd;

  wws_fifo #(.DEPTH(MQ_DEPTH), .W(BW)) u_mq (
    .clk(clk), .rst_n(rst_n_q),
    .push_v(mq_push_valid), .push_d(mq_push_bank), .push_rdy(mq_push_ready),
    .pop(main_go), .head(mq_head), .empty(mq_empty), .full(mq_full), .count(mq_count)
  );

  wws_fifo #(.DEPTH(EQ_DEPTH), .W(BW)) u_eq (
    .clk(clk), .rst_n(rst_n_q),
    .push_v(eq_push_valid), .push_d(eq_push_bank), .push_rdy(eq_push_ready),
    .pop(eager_go), .head(eq_head), .empty(eq_empty), .full(eq_full), .count(eq_count)
  );

  wws_bank_track #(
    .NUM_BANKS(NUM_BANKS), .MQ_DEPTH(MQ_DEPTH),
    .SLOW_CYCLES(SLOW_CYCLES), .FAST_CYCLES(FAST_CYCLES)
  ) u_track (
    .clk(clk), .rst_n(rst_n_q),
    .add_v(mq_push_valid && mq_push_ready), .add_bank(mq_push_bank),
    .sub_v(main_go), .sub_bank(mq_head),
    .iss_v(wr_valid), .iss_bank(wr_bank), .iss_slow(wr_slow),
    .pend(pend), .busy(busy)
  );

  wws_wear_quota #(.FAST_QUOTA(FAST_QUOTA), .PERIOD_CYCLES(PERIOD_CYCLES)) u_quota (
    .clk(clk), .rst_n(rst_n_q),
    .fast_issue(wr_valid && !wr_slow), .spent(quota_hit)
  );

  // issue arbitration: reads, then main queue, then eager queue
  always_comb begin
    main_go  = !rd_busy && !mq_empty && !busy[mq_head];
    eager_go = !rd_busy && !eq_empty && !main_go && !busy[eq_head];
    if (quota_hit)                                          main_spd = SPD_SLOW;
    else if (!fb_q && (pend[mq_head] <= PW'(FREE_THRESH)))  main_spd = SPD_SLOW;
    else                                                    main_spd = SPD_FAST;
    wr_valid = main_go || eager_go;
    wr_bank  = main_go ? mq_head : eq_head;
    wr_slow  = main_go ? (main_spd == SPD_SLOW) : 1'b1;
    wr_eager = eager_go;
  end

  // fallback to fast writes while the main queue is congested
  always_comb begin
    fb_d = fb_q;
    if (mq_full)                             fb_d = 1'b1;
    else if (mq_count < MQ_CW'(FALLBACK_LOW)) fb_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) fb_q <= 1'b0;
    else          fb_q <= fb_d;
  end
endmodule

// File: rtl/wws_checker.sv
module wws_checker #(
  parameter int BW    = 2,
  parameter int MQ_CW = 4,
  parameter int EQ_CW = 3
) (
  input logic             clk,
  input logic             rst_n_q,
  input logic             rd_busy,
  input logic             wr_valid,
  input logic [BW-1:0]    wr_bank,
  input logic             wr_slow,
  input logic             wr_eager,
  input logic             mq_push_ready,
  input logic             eq_push_ready,
  input logic             mq_full,
  input logic [MQ_CW-1:0] mq_count,
  input logic [EQ_CW-1:0] eq_count,
  input logic             quota_hit
);
  assert_bank_gap_R3: assert property (@(posedge clk) disable iff (!rst_n_q)
    wr_valid |=> !(wr_valid && (wr_bank == $past(wr_bank))));

  assert_no_issue_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n_q)
    rd_busy |-> !wr_valid);

  assert_eager_slow_R5: assert property (@(posedge clk) disable iff (!rst_n_q)
    (wr_valid && wr_eager) |-> wr_slow);

  assert_main_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n_q)
    !mq_push_ready |=> (mq_count <= $past(mq_count)));

  assert_eager_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n_q)
    !eq_push_ready |=> (eq_count <= $past(eq_count)));

  assert_quota_slow_R7: assert property (@(posedge clk) disable iff (!rst_n_q)
    (quota_hit && wr_valid) |-> wr_slow);

  assert_fallback_fast_R8: assert property (@(posedge clk) disable iff (!rst_n_q)
    mq_full |=> (!wr_valid || wr_eager || !wr_slow || quota_hit));

  assert_idle_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n_q)
    ((mq_count == '0) && (eq_count == '0)) |-> !wr_valid);
endmodule

bind wear_write_sched wws_checker #(.BW(BW), .MQ_CW(MQ_CW), .EQ_CW(EQ_CW)) u_chk (
  .clk(clk), .rst_n_q(rst_n_q), .rd_busy(rd_busy),
  .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_slow(wr_slow), .wr_eager(wr_eager),
  .mq_push_ready(mq_push_ready), .eq_push_ready(eq_push_ready),
  .mq_full(mq_full), .mq_count(mq_count), .eq_count(eq_count), .quota_hit(quota_hit)
);

// File: tb/wear_write_sched_tb.sv
module wear_write_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 8;
  localparam int BW   = $clog2(NB);
  localparam int PER  = 300;

  typedef struct packed {
    int n;
    int bank;
    int slow;
    int gap;
  } row_t;

  // n pushes to one bank; speed of the first write; cycles to the second
  localparam row_t ROWS [5] = '{
    '{1, 0, 1, 0},
    '{2, 1, 1, 6},
    '{3, 2, 0, 2},
    '{5, 3, 0, 2},
    '{4, 7, 0, 2}
  };

  logic clk, rst_n, rd_busy;
  logic mq_v, mq_rdy, eq_v, eq_rdy;
  logic [BW-1:0] mq_b, eq_b;
  logic wr_valid, wr_slow, wr_eager;
  logic [BW-1:0] wr_bank;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nlog = 0;
  int lg_bank [32];
  int lg_slow [32];
  int lg_eag  [32];
  int lg_cyc  [32];

  wear_write_sched #(
    .NUM_BANKS(NB), .MQ_DEPTH(8), .EQ_DEPTH(4), .FREE_THRESH(2),
    .FALLBACK_LOW(7), .SLOW_CYCLES(6), .FAST_CYCLES(2),
    .FAST_QUOTA(4), .PERIOD_CYCLES(PER)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_busy(rd_busy),
    .mq_push_valid(mq_v), .mq_push_bank(mq_b), .mq_push_ready(mq_rdy),
    .eq_push_valid(eq_v), .eq_push_bank(eq_b), .eq_push_ready(eq_rdy),
    .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_slow(wr_slow), .wr_eager(wr_eager)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wr_valid && nlog < 32) begin
      lg_bank[nlog] = int'(wr_bank);
      lg_slow[nlog] = int'(wr_slow);
      lg_eag[nlog]  = int'(wr_eager);
      lg_cyc[nlog]  = cyc;
      nlog = nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rd_busy = 1'b1; mq_v = 1'b0; eq_v = 1'b0; mq_b = '0; eq_b = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 nlog = 0;
  endtask

  task automatic push_m(input int b);
    mq_v = 1'b1; mq_b = BW'(b);
    @(posedge clk); #1 mq_v = 1'b0;
  endtask

  task automatic push_e(input int b);
    eq_v = 1'b1; eq_b = BW'(b);
    @(posedge clk); #1 eq_v = 1'b0;
  endtask

  task automatic run_for(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rst_cyc;
    // R9: reset state
    do_reset();
    rd_busy = 1'b0;
    run_for(4);
    chk(nlog == 0, "R9 no write after reset", nlog, 0);
    chk(mq_rdy == 1'b1, "R9 main ready after reset", int'(mq_rdy), 1);
    chk(eq_rdy == 1'b1, "R9 eager ready after reset", int'(eq_rdy), 1);

    // R1 R2 R3: table of occupancy patterns
    foreach (ROWS[i]) begin
      do_reset();
      for (int k = 0; k < ROWS[i].n; k++) push_m(ROWS[i].bank);
      chk(nlog == 0, "R4 held by read", nlog, 0);
      rd_busy = 1'b0;
      run_for(60);
      chk(nlog == ROWS[i].n, "R1 write count", nlog, ROWS[i].n);
      chk(lg_bank[0] == ROWS[i].bank, "R1 bank", lg_bank[0], ROWS[i].bank);
      chk(lg_slow[0] == ROWS[i].slow, ROWS[i].slow ? "R1 slow when free" : "R2 fast when loaded",
          lg_slow[0], ROWS[i].slow);
      if (ROWS[i].n >= 2)
        chk(lg_cyc[1] - lg_cyc[0] == ROWS[i].gap, "R3 bank busy gap",
            lg_cyc[1] - lg_cyc[0], ROWS[i].gap);
    end

    // R8 R6 R4: full main queue, fallback, refusal, order
    do_reset();
    for (int k = 0; k < 8; k++) push_m(k);
    chk(mq_rdy == 1'b0, "R6 main not ready when full", int'(mq_rdy), 0);
    push_m(0);
    rd_busy = 1'b0;
    run_for(40);
    chk(nlog == 8, "R6 refused entry dropped", nlog, 8);
    for (int k = 0; k < 8; k++) begin
      chk(lg_bank[k] == k, "R4 arrival order", lg_bank[k], k);
      chk(lg_slow[k] == (k >= 3 ? 1 : 0), "R8 fallback speed", lg_slow[k], (k >= 3 ? 1 : 0));
    end
    chk(lg_cyc[7] - lg_cyc[0] == 7, "R3 other banks not blocked", lg_cyc[7] - lg_cyc[0], 7);

    // R5: eager waits for the main queue
    do_reset();
    push_e(2);
    push_m(0);
    rd_busy = 1'b0;
    run_for(30);
    chk(nlog == 2, "R5 two writes", nlog, 2);
    chk(lg_eag[0] == 0 && lg_bank[0] == 0, "R4 main first", lg_bank[0], 0);
    chk(lg_eag[1] == 1 && lg_bank[1] == 2, "R5 eager second", lg_bank[1], 2);
    chk(lg_slow[1] == 1, "R5 eager slow", lg_slow[1], 1);
    chk(lg_cyc[1] - lg_cyc[0] == 1, "R5 eager next cycle", lg_cyc[1] - lg_cyc[0], 1);

    // R5: eager fills a cycle where the main head is blocked
    do_reset();
    push_m(0);
    push_m(0);
    push_e(1);
    rd_busy = 1'b0;
    run_for(30);
    chk(nlog == 3, "R5 three writes", nlog, 3);
    chk(lg_eag[1] == 1 && lg_bank[1] == 1, "R5 eager in blocked cycle", lg_bank[1], 1);
    chk(lg_cyc[2] - lg_cyc[0] == 6 && lg_bank[2] == 0, "R3 slow gap", lg_cyc[2] - lg_cyc[0], 6);

    // R6: eager queue full
    do_reset();
    for (int k = 0; k < 4; k++) push_e(k);
    chk(eq_rdy == 1'b0, "R6 eager not ready when full", int'(eq_rdy), 0);
    push_e(5);
    rd_busy = 1'b0;
    run_for(40);
    chk(nlog == 4, "R6 eager refused entry dropped", nlog, 4);
    for (int k = 0; k < nlog; k++)
      chk(lg_bank[k] != 5 && lg_slow[k] == 1, "R5 eager slow", lg_slow[k], 1);

    // R7: wear budget
    do_reset();
    rst_cyc = cyc;
    for (int k = 0; k < 7; k++) push_m(0);
    rd_busy = 1'b0;
    run_for(50);
    chk(nlog == 7, "R7 write count", nlog, 7);
    for (int k = 0; k < 7; k++)
      chk(lg_slow[k] == (k >= 4 ? 1 : 0), "R7 budget", lg_slow[k], (k >= 4 ? 1 : 0));
    rd_busy = 1'b1; nlog = 0;
    for (int k = 0; k < 4; k++) push_m(0);
    rd_busy = 1'b0;
    run_for(40);
    chk(lg_slow[0] == 1, "R7 forced slow in spent period", lg_slow[0], 1);
    while (cyc < rst_cyc + PER + 20) run_for(1);
    rd_busy = 1'b1; nlog = 0;
    for (int k = 0; k < 4; k++) push_m(0);
    rd_busy = 1'b0;
    run_for(40);
    chk(lg_slow[0] == 0, "R7 budget refilled", lg_slow[0], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule